// File: doc/BRIEF.md
# I2C Bus Condition and Error Monitor

This block watches the SCL and SDA lines of a two-wire serial bus from inside a host/client controller. It passes both lines through a two-flop synchronizer and reports start, repeated-start and stop conditions as one-cycle strobes. It also keeps a bus-idle indication and watches for three bus faults: SCL held low too long (time-out), SDA low while the controller expects both lines released (collision), and a not-acknowledge on the 9th clock pulse.

Each fault sets a sticky flag that only software clears. Each flag has its own interrupt enable feeding a shared sticky error interrupt. The surrounding controller gets recovery requests back. These are a module reset, clear requests for its client-active and clock-stretch state, and an automatic NACK when one of its four buffer error statuses rises. For a host, it also gets a deferred stop request and then a host-active clear once that stop has been seen on the bus.

A time-out is handled by role. An active client is reset at once. An active host waits until the bus is idle, asks for a stop, and releases host-active only after the stop condition is seen.

Top module: `i2c_bus_monitor`

## Requirements
- R1: A falling SDA edge while SCL is high, seen on the synchronized lines with the bus not busy, gives a one-cycle `start_det` pulse. The pulse appears in the cycle after the second rising clock edge that samples the new raw level. The bus then counts as busy.
- R2: The same falling-SDA-with-SCL-high edge while the bus is busy gives a one-cycle `restart_det` pulse and no `start_det`.
- R3: A rising SDA edge while SCL is high gives a one-cycle `stop_det` pulse, with the same latency as R1, and the bus is no longer busy.
- R4: `bus_idle` is high while the synchronized SCL and SDA are both high and have been high for at least `idle_len` earlier consecutive cycles. Reset restarts that count.
- R5: Time-out: on the `tmo_period`-th consecutive cycle with synchronized SCL low, time-out flag bit 0 is set one cycle later. This happens once per low stretch. If `client_active` is high, `mod_reset_req`, `client_clr_req` and `stretch_clr_req` each pulse for one cycle at the same time.
- R6: A time-out with `host_active` high arms host recovery. `stop_gen_req` pulses once in the cycle after `bus_idle` is next seen high. `host_clr_req` then pulses once in the cycle after the next `stop_det`.
- R7: Collision: `expect_high` high while synchronized SDA is low sets flag bit 1 and pulses `mod_reset_req` one cycle later.
- R8: NACK: with `host_active` or `client_active` high, `ninth_pulse` high and synchronized SDA high, flag bit 2 is set one cycle later.
- R9: A rise of any bit of `buf_err` pulses `auto_nack_req` once, sets flag bit 2, and sets `err_irq`, whatever `err_en` holds.
- R10: `err_irq` is set one cycle after a flag event whose bit in `err_en` is high, stays set, and is cleared by `irq_clr`. A new event in the same cycle wins over the clear.
- R11: A flag bit stays set until a 1 is written to the same bit of `flag_clr`. A new event in the same cycle wins over the clear. Bit 0 is time-out, bit 1 is collision, bit 2 is NACK, and the same layout applies to `err_en` and `flag_clr`.
- R12: With `rst` high at a clock edge, all flags, strobes, requests and `err_irq` are 0, and `bus_idle` is 0 unless `idle_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Unsynchronized SCL line level |
| sda_raw | input | 1 | Unsynchronized SDA line level |
| host_active | input | 1 | Controller is active as host |
| client_active | input | 1 | Controller is active as client |
| expect_high | input | 1 | Controller expects both lines released |
| ninth_pulse | input | 1 | Marks the acknowledge (9th) SCL pulse |
| buf_err | input | BUF_N (4) | Transmit-write, receive-read, transmit-underflow, receive-overflow statuses |
| tmo_period | input | TMO_W | SCL-low cycles that make a time-out (at least 1) |
| idle_len | input | IDLE_W | Both-high cycles needed for bus idle |
| err_en | input | 3 | Interrupt enables: bit0 time-out, bit1 collision, bit2 NACK |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| irq_clr | input | 1 | Clears the error interrupt |
| start_det | output | 1 | Start condition strobe |
| restart_det | output | 1 | Repeated start strobe |
| stop_det | output | 1 | Stop condition strobe |
| bus_idle | output | 1 | Bus idle indication |
| err_flags | output | 3 | Sticky error flags: bit0 time-out, bit1 collision, bit2 NACK |
| err_irq | output | 1 | Sticky error interrupt |
| mod_reset_req | output | 1 | Module reset request pulse |
| stop_gen_req | output | 1 | Request to drive a stop (host recovery) |
| client_clr_req | output | 1 | Request to clear client-active |
| stretch_clr_req | output | 1 | Request to clear clock stretching |
| host_clr_req | output | 1 | Request to clear host-active |
| auto_nack_req | output | 1 | Request to answer with a NACK |

## Verification
A wrong busy bit shows within the same cycle as the next falling SDA edge: `start_det` and `restart_det` swap. A wrong idle or low-time counter moves `bus_idle` or the time-out flag by one or more cycles, and the per-cycle comparison against the model catches that shift on the first cycle it occurs. A host recovery state that is stuck or that skips a step leaves out `stop_gen_req` or `host_clr_req`, or sends one of them early. This shows within a cycle of the idle or stop event that should release it. Flag and interrupt errors show one cycle after the event or the clear write.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    localparam int ERR_N    = 3;
    localparam int ERR_TMO  = 0;
    localparam int ERR_COL  = 1;
    localparam int ERR_NACK = 2;
    localparam int BUF_N    = 4;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    typedef struct packed {
        logic start;
        logic restart;
        logic stop;
        logic idle;
    } bus_cond_t;

    typedef enum logic [1:0] {
        HREC_NONE,
        HREC_WAIT_IDLE,
        HREC_WAIT_STOP
    } host_rec_e;

    localparam line_t LINE_RELEASED = '{scl: 1'b1, sda: 1'b1};

    // SDA moves to 'rising' while SCL stays high on both samples
    function automatic logic sda_edge_scl_high(line_t p, line_t c, logic rising);
        return p.scl & c.scl & (p.sda == ~rising) & (c.sda == rising);
    endfunction

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync
    import i2cmon_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  line_t raw,
    output line_t synced
);
    line_t chain [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= LINE_RELEASED;
                    else     chain[i] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= LINE_RELEASED;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign synced = chain[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond
    import i2cmon_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  line_t             cur,
    input  logic [IDLE_W-1:0] idle_len,
    output bus_cond_t         cond
);
    line_t             prev;
    logic              busy;
    logic [IDLE_W-1:0] hi_cnt;
    logic              fell_hi, rose_hi, both_hi;

    always_comb begin
        both_hi      = cur.scl & cur.sda;
        fell_hi      = sda_edge_scl_high(prev, cur, 1'b0);
        rose_hi      = sda_edge_scl_high(prev, cur, 1'b1);
        cond.start   = fell_hi & ~busy;
        cond.restart = fell_hi & busy;
        cond.stop    = rose_hi;
        cond.idle    = both_hi & (hi_cnt == idle_len);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= LINE_RELEASED;
            busy   <= 1'b0;
            hi_cnt <= '0;
        end else begin
            prev <= cur;
            if (fell_hi)      busy <= 1'b1;
            else if (rose_hi) busy <= 1'b0;
            if (!both_hi)                hi_cnt <= '0;
            else if (hi_cnt != idle_len) hi_cnt <= hi_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cmon_tmo.sv
module i2cmon_tmo #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl,
    input  logic [TMO_W-1:0] period,
    output logic             fire
);
    logic [TMO_W-1:0] low_cnt;

    // low_cnt counts earlier low cycles; saturating at period makes fire one-shot
    assign fire = ~scl & (low_cnt != period) & (low_cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || scl)           low_cnt <= '0;
        else if (low_cnt != period) low_cnt <= low_cnt + 1'b1;
    end
endmodule

// File: rtl/i2cmon_err.sv
module i2cmon_err
    import i2cmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sda_s,
    input  logic             expect_high,
    input  logic             host_active,
    input  logic             client_active,
    input  logic             ninth_pulse,
    input  logic [BUF_N-1:0] buf_err,
    input  logic             tmo_fire,
    input  logic             bus_idle,
    input  logic             stop_seen,
    input  logic [ERR_N-1:0] err_en,
    input  logic [ERR_N-1:0] flag_clr,
    input  logic             irq_clr,
    output logic [ERR_N-1:0] err_flags,
    output logic             err_irq,
    output logic             mod_reset_req,
    output logic             stop_gen_req,
    output logic             client_clr_req,
    output logic             stretch_clr_req,
    output logic             host_clr_req,
    output logic             auto_nack_req
);
    logic [BUF_N-1:0] buf_prev;
    logic             buf_rise;
    logic [ERR_N-1:0] ev;
    logic             client_tmo;
    host_rec_e        hrec;

    always_comb begin
        buf_rise      = |(buf_err & ~buf_prev);
        client_tmo    = tmo_fire & client_active;
        ev            = '0;
        ev[ERR_TMO]   = tmo_fire;
        ev[ERR_COL]   = expect_high & ~sda_s;
        ev[ERR_NACK]  = ((host_active | client_active) & ninth_pulse & sda_s) | buf_rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_prev        <= '0;
            err_flags       <= '0;
            err_irq         <= 1'b0;
            mod_reset_req   <= 1'b0;
            client_clr_req  <= 1'b0;
            stretch_clr_req <= 1'b0;
            auto_nack_req   <= 1'b0;
            stop_gen_req    <= 1'b0;
            host_clr_req    <= 1'b0;
            hrec            <= HREC_NONE;
        end else begin
            buf_prev        <= buf_err;
            err_flags       <= (err_flags & ~flag_clr) | ev;
            err_irq         <= (err_irq & ~irq_clr) | (|(ev & err_en)) | buf_rise;
            mod_reset_req   <= ev[ERR_COL] | client_tmo;
            client_clr_req  <= client_tmo;
            stretch_clr_req <= client_tmo;
            auto_nack_req   <= buf_rise;
            stop_gen_req    <= 1'b0;
            host_clr_req    <= 1'b0;
            unique case (hrec)
                HREC_NONE:
                    if (tmo_fire && host_active) hrec <= HREC_WAIT_IDLE;
                HREC_WAIT_IDLE:
                    if (bus_idle) begin
                        stop_gen_req <= 1'b1;
                        hrec         <= HREC_WAIT_STOP;
                    end
                HREC_WAIT_STOP:
                    if (stop_seen) begin
                        host_clr_req <= 1'b1;
                        hrec         <= HREC_NONE;
                    end
                default: hrec <= HREC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2cmon_pkg::*;
#(
    parameter int TMO_W       = 16,
    parameter int IDLE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_raw,
    input  logic              sda_raw,
    input  logic              host_active,
    input  logic              client_active,
    input  logic              expect_high,
    input  logic              ninth_pulse,
    input  logic [BUF_N-1:0]  buf_err,
    input  logic [TMO_W-1:0]  tmo_period,
    input  logic [IDLE_W-1:0] idle_len,
    input  logic [ERR_N-1:0]  err_en,
    input  logic [ERR_N-1:0]  flag_clr,
    input  logic              irq_clr,
    output logic              start_det,
    output logic              restart_det,
    output logic              stop_det,
    output logic              bus_idle,
    output logic [ERR_N-1:0]  err_flags,
    output logic              err_irq,
    output logic              mod_reset_req,
    output logic              stop_gen_req,
    output logic              client_clr_req,
    output logic              stretch_clr_req,
    output logic              host_clr_req,
    output logic              auto_nack_req
);
    line_t     raw_lines, lines_s;
    bus_cond_t cond;
    logic      tmo_fire;
    logic      scl_s, sda_s;

    assign raw_lines = '{scl: scl_raw, sda: sda_raw};
    assign scl_s     = lines_s.scl;
    assign sda_s     = lines_s.sda;

    i2cmon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(raw_lines), .synced(lines_s)
    );

    i2cmon_cond #(.IDLE_W(IDLE_W)) u_cond (
        .clk(clk), .rst(rst), .cur(lines_s), .idle_len(idle_len), .cond(cond)
    );

    i2cmon_tmo #(.TMO_W(TMO_W)) u_tmo (
        .clk(clk), .rst(rst), .scl(scl_s), .period(tmo_period), .fire(tmo_fire)
    );

    i2cmon_err u_err (
        .clk(clk), .rst(rst), .sda_s(sda_s), .expect_high(expect_high),
        .host_active(host_active), .client_active(client_active),
        .ninth_pulse(ninth_pulse), .buf_err(buf_err), .tmo_fire(tmo_fire),
        .bus_idle(cond.idle), .stop_seen(cond.stop), .err_en(err_en),
        .flag_clr(flag_clr), .irq_clr(irq_clr), .err_flags(err_flags),
        .err_irq(err_irq), .mod_reset_req(mod_reset_req),
        .stop_gen_req(stop_gen_req), .client_clr_req(client_clr_req),
        .stretch_clr_req(stretch_clr_req), .host_clr_req(host_clr_req),
        .auto_nack_req(auto_nack_req)
    );

    assign start_det   = cond.start;
    assign restart_det = cond.restart;
    assign stop_det    = cond.stop;
    assign bus_idle    = cond.idle;
endmodule

// File: rtl/i2cmon_chk.sv
module i2cmon_chk (
    input logic       clk,
    input logic       rst,
    input logic       sda_s,
    input logic       expect_high,
    input logic       host_active,
    input logic       client_active,
    input logic       ninth_pulse,
    input logic [3:0] buf_err,
    input logic [2:0] flag_clr,
    input logic       start_det,
    input logic       restart_det,
    input logic       stop_det,
    input logic       bus_idle,
    input logic [2:0] err_flags,
    input logic       err_irq,
    input logic       mod_reset_req,
    input logic       stop_gen_req,
    input logic       client_clr_req,
    input logic       stretch_clr_req,
    input logic       host_clr_req,
    input logic       auto_nack_req
);
    // R2
    start_restart_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_det, restart_det, stop_det}));

    // R7
    collision_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (expect_high && !sda_s) |=> (err_flags[1] && mod_reset_req));

    // R8
    nack_flag_chk: assert property (@(posedge clk) disable iff (rst)
        ((host_active || client_active) && ninth_pulse && sda_s) |=> err_flags[2]);

    // R9
    buf_err_nack_chk: assert property (@(posedge clk) disable iff (rst)
        auto_nack_req |-> (err_flags[2] && err_irq));

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(err_flags) & ~$past(flag_clr)) & ~err_flags) == 3'b000));

    // R5
    client_recover_chk: assert property (@(posedge clk) disable iff (rst)
        client_clr_req |-> (mod_reset_req && stretch_clr_req && err_flags[0]));

    // R6
    stop_after_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_gen_req |-> $past(bus_idle));

    // R6
    host_clr_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
        host_clr_req |-> $past(stop_det));

    // R9
    buf_rise_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(buf_err[0]) || $rose(buf_err[1]) || $rose(buf_err[2]) || $rose(buf_err[3]))
        |=> auto_nack_req);
endmodule

bind i2c_bus_monitor i2cmon_chk u_chk (
    .clk(clk), .rst(rst), .sda_s(sda_s), .expect_high(expect_high),
    .host_active(host_active), .client_active(client_active),
    .ninth_pulse(ninth_pulse), .buf_err(buf_err), .flag_clr(flag_clr),
    .start_det(start_det), .restart_det(restart_det), .stop_det(stop_det),
    .bus_idle(bus_idle), .err_flags(err_flags), .err_irq(err_irq),
    .mod_reset_req(mod_reset_req), .stop_gen_req(stop_gen_req),
    .client_clr_req(client_clr_req), .stretch_clr_req(stretch_clr_req),
    .host_clr_req(host_clr_req), .auto_nack_req(auto_nack_req)
);

// File: tb/i2c_bus_monitor_bench.sv
`timescale 1ns/1ps
module i2c_bus_monitor_bench;
    localparam int TMO_W  = 16;
    localparam int IDLE_W = 8;
    localparam int PERIOD = 10;
    localparam int IDLE_N = 6;

    logic clk = 1'b0;
    logic rst, scl_raw, sda_raw, host_active, client_active, expect_high, ninth_pulse, irq_clr;
    logic [3:0] buf_err;
    logic [2:0] err_en, flag_clr;
    logic start_det, restart_det, stop_det, bus_idle, err_irq, mod_reset_req;
    logic stop_gen_req, client_clr_req, stretch_clr_req, host_clr_req, auto_nack_req;
    logic [2:0] err_flags;

    always #4 clk = ~clk;

    i2c_bus_monitor #(.TMO_W(TMO_W), .IDLE_W(IDLE_W)) u_i2c_bus_monitor (
        .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
        .host_active(host_active), .client_active(client_active),
        .expect_high(expect_high), .ninth_pulse(ninth_pulse), .buf_err(buf_err),
        .tmo_period(16'(PERIOD)), .idle_len(8'(IDLE_N)), .err_en(err_en),
        .flag_clr(flag_clr), .irq_clr(irq_clr), .start_det(start_det),
        .restart_det(restart_det), .stop_det(stop_det), .bus_idle(bus_idle),
        .err_flags(err_flags), .err_irq(err_irq), .mod_reset_req(mod_reset_req),
        .stop_gen_req(stop_gen_req), .client_clr_req(client_clr_req),
        .stretch_clr_req(stretch_clr_req), .host_clr_req(host_clr_req),
        .auto_nack_req(auto_nack_req)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    // ---------------- reference model ----------------
    bit hs[$];          // synchronizer history of SCL, newest first
    bit hd[$];          // synchronizer history of SDA
    bit m_busy;
    int high_run, low_run, hstate;
    bit [3:0] m_buf_prev;
    bit [2:0] e_flags;
    bit e_irq, e_mrst, e_sgen, e_cclr, e_sclr, e_hclr, e_anack;
    bit e_start, e_restart, e_stop, e_idle;

    always @(posedge clk) begin
        if (rst) begin
            hs = '{1, 1, 1}; hd = '{1, 1, 1};
            m_busy = 0; high_run = 0; low_run = 0; hstate = 0; m_buf_prev = 0;
            e_flags = 0; {e_irq, e_mrst, e_sgen, e_cclr, e_sclr, e_hclr, e_anack} = 0;
        end else begin
            bit os, od, ps, pd, fell, rose, idle_old, fire, col, nack, brise;
            bit [2:0] ev;
            os = hs[1]; od = hd[1]; ps = hs[2]; pd = hd[2];
            fell = ps && os && pd && !od;
            rose = ps && os && !pd && od;
            idle_old = os && od && (high_run == IDLE_N);
            fire = !os && (low_run == PERIOD - 1);
            col = expect_high && !od;
            brise = (buf_err & ~m_buf_prev) != 0;
            nack = ((host_active || client_active) && ninth_pulse && od) || brise;
            ev = {nack, col, fire};
            e_flags = (e_flags & ~flag_clr) | ev;
            e_irq = (e_irq && !irq_clr) || ((ev & err_en) != 0) || brise;
            e_mrst = col || (fire && client_active);
            e_cclr = fire && client_active;
            e_sclr = e_cclr;
            e_anack = brise;
            e_sgen = 0; e_hclr = 0;
            if (hstate == 0 && fire && host_active) hstate = 1;
            else if (hstate == 1 && idle_old) begin e_sgen = 1; hstate = 2; end
            else if (hstate == 2 && rose) begin e_hclr = 1; hstate = 0; end
            if (fell) m_busy = 1; else if (rose) m_busy = 0;
            if (os && od) begin if (high_run < IDLE_N) high_run++; end else high_run = 0;
            if (!os) begin if (low_run < PERIOD) low_run++; end else low_run = 0;
            m_buf_prev = buf_err;
            hs.push_front(scl_raw); void'(hs.pop_back());
            hd.push_front(sda_raw); void'(hd.pop_back());
        end
        begin
            bit f2, r2;
            f2 = hs[2] && hs[1] && hd[2] && !hd[1];
            r2 = hs[2] && hs[1] && !hd[2] && hd[1];
            e_start = f2 && !m_busy;
            e_restart = f2 && m_busy;
            e_stop = r2;
            e_idle = hs[1] && hd[1] && (high_run == IDLE_N);
        end
    end

    // per-cycle comparison, away from the active edge
    int n_start, n_restart, n_stop, n_mrst, n_sgen, n_hclr, n_anack, n_cclr;
    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R1 start_det", start_det, e_start);
            check("R2 restart_det", restart_det, e_restart);
            check("R3 stop_det", stop_det, e_stop);
            check("R4 bus_idle", bus_idle, e_idle);
            check("R11 err_flags", err_flags, e_flags);
            check("R10 err_irq", err_irq, e_irq);
            check("R5 R7 mod_reset_req", mod_reset_req, e_mrst);
            check("R5 client_clr_req", client_clr_req, e_cclr);
            check("R5 stretch_clr_req", stretch_clr_req, e_sclr);
            check("R6 stop_gen_req", stop_gen_req, e_sgen);
            check("R6 host_clr_req", host_clr_req, e_hclr);
            check("R9 auto_nack_req", auto_nack_req, e_anack);
            n_start += start_det; n_restart += restart_det; n_stop += stop_det;
            n_mrst += mod_reset_req; n_sgen += stop_gen_req; n_hclr += host_clr_req;
            n_anack += auto_nack_req; n_cclr += client_clr_req;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic clear_counts();
        n_start = 0; n_restart = 0; n_stop = 0; n_mrst = 0;
        n_sgen = 0; n_hclr = 0; n_anack = 0; n_cclr = 0;
    endtask

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; scl_raw = 1; sda_raw = 1; host_active = 0; client_active = 0;
        expect_high = 0; ninth_pulse = 0; buf_err = 0; err_en = 3'b111;
        flag_clr = 0; irq_clr = 0;
        clear_counts();
        tick(3);
        // R12 reset state
        check("R12 flags", err_flags, 0);
        check("R12 strobes", {start_det, restart_det, stop_det}, 0);
        check("R12 requests", {mod_reset_req, stop_gen_req, client_clr_req,
                               stretch_clr_req, host_clr_req, auto_nack_req, err_irq}, 0);
        check("R12 bus_idle", bus_idle, 0);
        rst = 0;
        tick(12);
        check("R4 idle after reset", bus_idle, 1);

        // start, data, NACK on 9th pulse
        sda_raw = 0; tick(4);
        check("R1 one start", n_start, 1);
        check("R4 idle drops", bus_idle, 0);
        scl_raw = 0; tick(2);
        sda_raw = 1; tick(1); scl_raw = 1; tick(2); scl_raw = 0; tick(2);
        host_active = 1; ninth_pulse = 1; scl_raw = 1; tick(3);
        ninth_pulse = 0; scl_raw = 0; tick(3);
        check("R8 nack flag", err_flags[2], 1);
        host_active = 0;
        flag_clr = 3'b100; tick(1); flag_clr = 0; tick(2);
        check("R11 cleared", err_flags[2], 0);
        irq_clr = 1; tick(1); irq_clr = 0; tick(1);
        check("R10 irq cleared", err_irq, 0);

        // repeated start then stop
        scl_raw = 1; tick(2); sda_raw = 0; tick(4);
        check("R2 restart seen", n_restart, 1);
        check("R2 no extra start", n_start, 1);
        scl_raw = 0; tick(2); scl_raw = 1; tick(2); sda_raw = 1; tick(4);
        check("R3 stop seen", n_stop, 1);
        tick(8);

        // client time-out
        clear_counts();
        client_active = 1; scl_raw = 0; tick(PERIOD + 8);
        check("R5 tmo flag", err_flags[0], 1);
        check("R5 one reset", n_mrst, 1);
        check("R5 client clear", n_cclr, 1);
        client_active = 0; scl_raw = 1;
        flag_clr = 3'b001; irq_clr = 1; tick(1); flag_clr = 0; irq_clr = 0; tick(10);

        // host time-out, deferred stop
        clear_counts();
        host_active = 1; scl_raw = 0; tick(PERIOD + 6);
        check("R6 tmo flag", err_flags[0], 1);
        check("R6 no stop yet", n_sgen, 0);
        scl_raw = 1; tick(IDLE_N + 6);
        check("R6 stop request", n_sgen, 1);
        check("R6 host kept", n_hclr, 0);
        sda_raw = 0; tick(3); sda_raw = 1; tick(4);
        check("R6 host clear", n_hclr, 1);
        host_active = 0;
        flag_clr = 3'b111; irq_clr = 1; tick(1); flag_clr = 0; irq_clr = 0; tick(8);

        // collision with its enable off
        clear_counts();
        err_en = 3'b000;
        expect_high = 1; sda_raw = 0; tick(5); expect_high = 0; tick(2);
        check("R7 collision flag", err_flags[1], 1);
        check("R7 reset request", n_mrst > 0, 1);
        check("R10 no irq when disabled", err_irq, 0);
        sda_raw = 1; tick(6);

        // buffer error rise: auto NACK regardless of enable
        buf_err = 4'b0100; tick(4);
        check("R9 auto nack once", n_anack, 1);
        check("R9 nack flag", err_flags[2], 1);
        check("R9 irq", err_irq, 1);
        buf_err = 0; irq_clr = 1; flag_clr = 3'b111; tick(1); irq_clr = 0; flag_clr = 0; tick(2);

        // collision with enable on, clear racing a new event
        err_en = 3'b010;
        expect_high = 1; sda_raw = 0; tick(3);
        irq_clr = 1; flag_clr = 3'b010; tick(1); irq_clr = 0; flag_clr = 0; tick(1);
        check("R10 set beats clear", err_irq, 1);
        check("R11 set beats clear", err_flags[1], 1);
        expect_high = 0; sda_raw = 1; tick(6);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule